// File: doc/BRIEF.md
# Adaptive Voltage Scaling Controller

This block closes the loop between on-die speed sensors and the supply regulator of one core. It keeps a loop code, the voltage it believes is the lowest safe one for the present frequency target. From that code it derives the code it asks the regulator for. It lowers the code through margin searches, in which each step is proven with a path-probe test. Between searches it tracks a ring-oscillator count against a target, with a deadband around it. It reacts at once to timing-error flags. It also folds in a temporary droop boost, a power-cap ceiling and the codes used in deep idle.

The controller is a six-state machine. **DISABLED** holds the loop code at the maximum until `enable` rises (transition *start*). **LOWER** drops the loop code by one step, or moves on to TRACK once the minimum is reached (transition *floor*). **PROBE_REQ** waits until the regulator has settled and then pulses `probe_start` (transition *launch*). **PROBE_WAIT** waits for the probe result. A pass returns to LOWER (transition *pass*). A fail goes to TRACK one step up (transition *fail*). **TRACK** does steady-state tracking, and its search timer leads back to LOWER (transition *period*). **IDLE** is taken from any enabled state while `idle_req` is high (transition *sleep*). On wake-up the machine restarts from the maximum through LOWER (transition *wake*). A performance-state change does the same from any active state (transition *retarget*). A timing error leads to TRACK from any active state (transition *error*).

Regulator updates use a valid/acknowledge pair. After each acknowledged update the controller waits a programmable settle time before it issues a new update or uses a sensor sample again.

Top module: `avs_ctrl`

## Requirements
- R1: After reset `vr_code` equals the SAFE_CODE parameter (default 0xC0) and `vr_valid` is low. No probe test starts while `enable` is low, and during that time the loop code is held at `vmax_code`.
- R2: Once raised, `vr_valid` stays high with `vr_code` unchanged until a cycle with `vr_ack` high. After that, no new update is raised for `settle_cycles` cycles.
- R3: An update that raises the code moves it by exactly one step, except while `droop_alarm` is high. An update that lowers the code goes straight to the new target.
- R4: A margin search lowers the loop code one step at a time. It pulses `probe_start` once per step, and only when no update is pending or settling. On the first `probe_fail` the code returns one step up, to the last code that passed. The search stops at `vmin_code`. A search runs when `enable` rises, and again after `search_period` cycles of settled tracking.
- R5: In tracking, a sample with `osc_count` + `osc_band` < `osc_target` raises the loop code by one step, and a sample with `osc_count` > `osc_target` + `osc_band` lowers it by one step. A count within plus or minus `osc_band` of the target (bounds included) leaves the code unchanged.
- R6: A `ted_err` cycle raises the loop code by one step, never above `vmax_code`, and ends any search in progress.
- R7: While `droop_alarm` is high, the requested code is the loop code plus `droop_boost`, reached in a single update. After the alarm clears, the code returns to the loop code.
- R8: No update is ever raised with `vr_code` above `cap_code`. The cap wins even over `vmin_code`.
- R9: While `idle_req` is high, the code goes to `ret_code` when `idle_off_sel` is 0 and to zero when it is 1. Tracking samples and `ted_err` have no effect in that state.
- R10: On wake-up from idle, or on a `pstate_change` pulse, the loop code restarts at `vmax_code` and a new margin search runs down to the lowest passing code.
- R11: Outside idle, droop boost and cap, the loop code stays between `vmin_code` and `vmax_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enables adaptation |
| idle_req | input | 1 | Deep idle request |
| idle_off_sel | input | 1 | In idle: 1 selects zero, 0 selects the retention code |
| pstate_change | input | 1 | One-cycle pulse when the frequency target changes |
| osc_valid | input | 1 | One-cycle pulse: a new oscillator count is ready |
| osc_count | input | CW | Oscillator count over the sampling window |
| osc_target | input | CW | Expected count at the present frequency |
| osc_band | input | CW | Deadband half-width in counts |
| ted_err | input | 1 | Timing-error detect flag |
| droop_alarm | input | 1 | Supply droop alarm |
| droop_boost | input | VW | Boost added during droop |
| probe_start | output | 1 | Starts one path-probe test |
| probe_done | input | 1 | Probe result valid |
| probe_fail | input | 1 | Probe failed (valid with `probe_done`) |
| vmin_code | input | VW | Lowest loop code |
| vmax_code | input | VW | Highest loop code |
| ret_code | input | VW | Retention code for idle |
| cap_code | input | VW | Power-cap ceiling |
| search_period | input | TW | Settled tracking cycles between searches |
| settle_cycles | input | SW | Wait after each acknowledged update |
| vr_code | output | VW | Code sent to the regulator |
| vr_valid | output | 1 | Update pending |
| vr_ack | input | 1 | Regulator accepts the update |

## Verification
The hardest situation to reach is a margin search that starts from a state other than reset, such as a wake-up from the zero code or a performance-state change. It has to climb one step at a time back to the maximum and then probe its way down. The bench reaches it by keeping a probe model whose pass threshold it moves between phases, then asserting and releasing `idle_req` or pulsing `pstate_change`. It waits long enough for the climb, every settle window and every probe round trip to finish before it compares the settled code with the new threshold. A floor case sets the threshold below `vmin_code` so that the search has to stop at the limit.

// File: rtl/avs_pkg.sv
package avs_pkg;
    typedef enum logic [2:0] {
        ST_DISABLED,
        ST_LOWER,
        ST_PROBE_REQ,
        ST_PROBE_WAIT,
        ST_TRACK,
        ST_IDLE
    } avs_state_e;
endpackage

// File: rtl/avs_speed_cmp.sv
module avs_speed_cmp #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] target,
    input  logic [CW-1:0] band,
    output logic          too_slow,
    output logic          too_fast
);
    localparam int XW = CW + 1;

    logic [XW-1:0] cnt_plus_band;
    logic [XW-1:0] tgt_plus_band;

    always_comb begin
        cnt_plus_band = {1'b0, count}  + {1'b0, band};
        tgt_plus_band = {1'b0, target} + {1'b0, band};
        too_slow = cnt_plus_band < {1'b0, target};
        too_fast = {1'b0, count} > tgt_plus_band;
    end
endmodule

// File: rtl/avs_target.sv
module avs_target #(
    parameter int VW = 8
) (
    input  logic [VW-1:0] loop_code,
    input  logic [VW-1:0] vmin_code,
    input  logic [VW-1:0] vmax_code,
    input  logic [VW-1:0] cap_code,
    input  logic [VW-1:0] ret_code,
    input  logic [VW-1:0] droop_boost,
    input  logic          droop_on,
    input  logic          idle_on,
    input  logic          idle_off_sel,
    output logic [VW-1:0] target
);
    localparam logic [VW-1:0] CODE_TOP = {VW{1'b1}};

    logic [VW-1:0] bounded;
    logic [VW:0]   boost_sum;
    logic [VW-1:0] boosted;
    logic [VW-1:0] level;

    always_comb begin
        if (loop_code < vmin_code)      bounded = vmin_code;
        else if (loop_code > vmax_code) bounded = vmax_code;
        else                            bounded = loop_code;

        boost_sum = {1'b0, bounded} + {1'b0, droop_boost};
        boosted   = boost_sum[VW] ? CODE_TOP : boost_sum[VW-1:0];

        if (idle_on)       level = idle_off_sel ? '0 : ret_code;
        else if (droop_on) level = boosted;
        else               level = bounded;

        target = (level > cap_code) ? cap_code : level;
    end
endmodule

// File: rtl/avs_vr_port.sv
module avs_vr_port #(
    parameter int VW = 8,
    parameter int SW = 8,
    parameter logic [VW-1:0] SAFE_CODE = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] target,
    input  logic          droop_on,
    input  logic [SW-1:0] settle_cycles,
    input  logic          vr_ack,
    output logic [VW-1:0] vr_code,
    output logic          vr_valid,
    output logic          busy
);
    logic [SW-1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vr_code  <= SAFE_CODE;
            vr_valid <= 1'b0;
            settle_q <= '0;
        end else if (vr_valid) begin
            if (vr_ack) begin
                vr_valid <= 1'b0;
                settle_q <= settle_cycles;
            end
        end else if (settle_q != '0) begin
            settle_q <= settle_q - 1'b1;
        end else if (target != vr_code) begin
            vr_valid <= 1'b1;
            if (target < vr_code || droop_on) vr_code <= target;
            else                              vr_code <= vr_code + 1'b1;
        end
    end

    assign busy = vr_valid || (settle_q != '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_valid && !vr_ack) |=> (vr_valid && $stable(vr_code)));

    p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vr_valid && vr_ack && settle_cycles != '0) |=> !vr_valid);

    p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vr_valid) && !$past(droop_on) && vr_code > $past(vr_code))
        |-> vr_code == $past(vr_code) + 1'b1);
endmodule

// File: rtl/avs_ctrl.sv
module avs_ctrl
    import avs_pkg::*;
#(
    parameter int VW = 8,
    parameter int CW = 16,
    parameter int TW = 20,
    parameter int SW = 8,
    parameter logic [VW-1:0] SAFE_CODE = 8'hC0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          idle_req,
    input  logic          idle_off_sel,
    input  logic          pstate_change,
    input  logic          osc_valid,
    input  logic [CW-1:0] osc_count,
    input  logic [CW-1:0] osc_target,
    input  logic [CW-1:0] osc_band,
    input  logic          ted_err,
    input  logic          droop_alarm,
    input  logic [VW-1:0] droop_boost,
    output logic          probe_start,
    input  logic          probe_done,
    input  logic          probe_fail,
    input  logic [VW-1:0] vmin_code,
    input  logic [VW-1:0] vmax_code,
    input  logic [VW-1:0] ret_code,
    input  logic [VW-1:0] cap_code,
    input  logic [TW-1:0] search_period,
    input  logic [SW-1:0] settle_cycles,
    output logic [VW-1:0] vr_code,
    output logic          vr_valid,
    input  logic          vr_ack
);
    localparam int XTW = TW + 1;

    avs_state_e    st_q, st_n;
    logic [VW-1:0] loop_q, loop_n;
    logic [TW-1:0] tmr_q, tmr_n;
    logic [VW-1:0] target;
    logic          busy, settled;
    logic          too_slow, too_fast;
    logic          can_up, can_down;
    logic [XTW-1:0] tmr_inc;

    avs_speed_cmp #(.CW(CW)) u_cmp (
        .count   (osc_count),
        .target  (osc_target),
        .band    (osc_band),
        .too_slow(too_slow),
        .too_fast(too_fast)
    );

    avs_target #(.VW(VW)) u_tgt (
        .loop_code   (loop_q),
        .vmin_code   (vmin_code),
        .vmax_code   (vmax_code),
        .cap_code    (cap_code),
        .ret_code    (ret_code),
        .droop_boost (droop_boost),
        .droop_on    (droop_alarm),
        .idle_on     (st_q == ST_IDLE),
        .idle_off_sel(idle_off_sel),
        .target      (target)
    );

    avs_vr_port #(.VW(VW), .SW(SW), .SAFE_CODE(SAFE_CODE)) u_vr (
        .clk          (clk),
        .rst_n        (rst_n),
        .target       (target),
        .droop_on     (droop_alarm),
        .settle_cycles(settle_cycles),
        .vr_ack       (vr_ack),
        .vr_code      (vr_code),
        .vr_valid     (vr_valid),
        .busy         (busy)
    );

    assign settled  = !busy && (vr_code == target);
    assign can_up   = loop_q < vmax_code;
    assign can_down = loop_q > vmin_code;
    assign tmr_inc  = {1'b0, tmr_q} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_DISABLED;
            loop_q <= SAFE_CODE;
            tmr_q  <= '0;
        end else begin
            st_q   <= st_n;
            loop_q <= loop_n;
            tmr_q  <= tmr_n;
        end
    end

    // next-state logic
    always_comb begin
        st_n   = st_q;
        loop_n = loop_q;
        tmr_n  = tmr_q;
        if (!enable) begin
            st_n   = ST_DISABLED;
            loop_n = vmax_code;
            tmr_n  = '0;
        end else if (idle_req) begin
            st_n  = ST_IDLE;
            tmr_n = '0;
        end else if (st_q == ST_DISABLED || st_q == ST_IDLE) begin
            st_n   = ST_LOWER;
            loop_n = vmax_code;
        end else if (pstate_change) begin
            st_n   = ST_LOWER;
            loop_n = vmax_code;
            tmr_n  = '0;
        end else if (ted_err) begin
            st_n   = ST_TRACK;
            loop_n = can_up ? loop_q + 1'b1 : loop_q;
            tmr_n  = '0;
        end else begin
            unique case (st_q)
                ST_LOWER: begin
                    if (can_down) begin
                        loop_n = loop_q - 1'b1;
                        st_n   = ST_PROBE_REQ;
                    end else begin
                        st_n = ST_TRACK;
                    end
                end
                ST_PROBE_REQ: begin
                    if (settled) st_n = ST_PROBE_WAIT;
                end
                ST_PROBE_WAIT: begin
                    if (probe_done) begin
                        if (probe_fail) begin
                            loop_n = loop_q + 1'b1;
                            st_n   = ST_TRACK;
                            tmr_n  = '0;
                        end else begin
                            st_n = ST_LOWER;
                        end
                    end
                end
                ST_TRACK: begin
                    if (settled) begin
                        if (tmr_inc >= {1'b0, search_period}) begin
                            st_n  = ST_LOWER;
                            tmr_n = '0;
                        end else begin
                            tmr_n = tmr_inc[TW-1:0];
                        end
                        if (osc_valid) begin
                            if (too_slow && can_up)
                                loop_n = loop_q + 1'b1;
                            else if (too_fast && can_down)
                                loop_n = loop_q - 1'b1;
                        end
                    end
                end
                ST_DISABLED, ST_IDLE: begin
                    st_n = ST_LOWER;
                end
                default: st_n = ST_DISABLED;
            endcase
        end
    end

    // outputs
    always_comb begin
        probe_start = (st_q == ST_PROBE_REQ) && settled && enable && !idle_req
                      && !pstate_change && !ted_err;
    end

    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vr_valid) |-> vr_code <= $past(cap_code));

    p_probe_settled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_start |-> !vr_valid);

    p_fail_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PROBE_WAIT && probe_done && probe_fail && enable && !idle_req
         && !pstate_change && !ted_err)
        |=> (loop_q == $past(loop_q) + 1'b1 && st_q == ST_TRACK));

    p_ted_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !idle_req && !pstate_change && ted_err && can_up
         && st_q != ST_DISABLED && st_q != ST_IDLE)
        |=> loop_q == $past(loop_q) + 1'b1);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && idle_req && enable) |=> $stable(loop_q));

    p_no_probe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !probe_start);
endmodule

// File: tb/tb_avs_ctrl.sv
module tb_avs_ctrl;
    localparam int VW = 8;
    localparam int CW = 16;
    localparam int TW = 20;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, idle_req = 1'b0, idle_off_sel = 1'b0, pstate_change = 1'b0;
    logic osc_valid = 1'b0;
    logic [CW-1:0] osc_count = 16'd1000, osc_target = 16'd1000, osc_band = 16'd8;
    logic ted_err = 1'b0, droop_alarm = 1'b0;
    logic [VW-1:0] droop_boost = 8'd5;
    logic probe_start;
    logic probe_done = 1'b0, probe_fail = 1'b0;
    logic [VW-1:0] vmin_code = 8'h40, vmax_code = 8'hC0, ret_code = 8'h50, cap_code = 8'hFF;
    logic [TW-1:0] search_period = 20'hFFFFF;
    logic [SW-1:0] settle_cycles = 8'd4;
    logic [VW-1:0] vr_code;
    logic vr_valid;
    logic vr_ack = 1'b0;

    int checks = 0, errors = 0;
    int probes_seen = 0;
    logic [VW-1:0] thr = 8'h90;
    bit done = 1'b0;

    always #4 clk = ~clk;

    avs_ctrl #(.VW(VW), .CW(CW), .TW(TW), .SW(SW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .idle_req(idle_req),
        .idle_off_sel(idle_off_sel), .pstate_change(pstate_change),
        .osc_valid(osc_valid), .osc_count(osc_count), .osc_target(osc_target),
        .osc_band(osc_band), .ted_err(ted_err), .droop_alarm(droop_alarm),
        .droop_boost(droop_boost), .probe_start(probe_start), .probe_done(probe_done),
        .probe_fail(probe_fail), .vmin_code(vmin_code), .vmax_code(vmax_code),
        .ret_code(ret_code), .cap_code(cap_code), .search_period(search_period),
        .settle_cycles(settle_cycles), .vr_code(vr_code), .vr_valid(vr_valid),
        .vr_ack(vr_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // regulator model: acknowledge two cycles after a request
    int ack_cnt = 0;
    always @(negedge clk) begin
        if (vr_valid && !vr_ack) begin
            ack_cnt++;
            if (ack_cnt == 2) vr_ack <= 1'b1;
        end else begin
            vr_ack  <= 1'b0;
            ack_cnt = 0;
        end
    end

    // probe model: passes when the applied code is at or above thr
    int pr_cnt = 0;
    always @(negedge clk) begin
        probe_done <= 1'b0;
        if (probe_start) pr_cnt = 3;
        else if (pr_cnt > 0) begin
            pr_cnt--;
            if (pr_cnt == 0) begin
                probe_done <= 1'b1;
                probe_fail <= (vr_code < thr);
            end
        end
    end

    // update monitor: sampled 2 ns after each rising edge
    logic prev_valid = 1'b0;
    logic [VW-1:0] prev_code = 8'hC0;
    int gap = 100;
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            if (vr_valid && !prev_valid) begin
                chk(vr_code <= cap_code, "R8 cap on update", vr_code, cap_code);
                chk(gap >= int'(settle_cycles), "R2 settle gap", gap, settle_cycles);
                if (!droop_alarm && vr_code > prev_code)
                    chk(vr_code == prev_code + 1'b1, "R3 one step up", vr_code, prev_code + 1);
            end
            if (prev_valid && !vr_ack)
                chk(vr_valid && vr_code == prev_code, "R2 hold until ack", vr_code, prev_code);
            if (probe_start) begin
                probes_seen++;
                chk(!vr_valid, "R4 probe only when settled", vr_valid, 0);
            end
            if (vr_ack && !vr_valid) gap = 0;
            else gap++;
            prev_valid = vr_valid;
            prev_code  = vr_code;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample(input int cnt);
        wait_cyc(30);
        osc_count = cnt[CW-1:0];
        osc_valid = 1'b1;
        @(negedge clk);
        osc_valid = 1'b0;
        wait_cyc(30);
    endtask

    function automatic int track_next(input int code, input int cnt);
        if (cnt + 8 < 1000 && code < int'(vmax_code)) return code + 1;
        if (cnt > 1008 && code > int'(vmin_code)) return code - 1;
        return code;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        int expc;
        int cnt;
        void'($urandom(32'd1234));
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(vr_code == 8'hC0, "R1 reset code", vr_code, 8'hC0);
        chk(!vr_valid, "R1 reset valid", vr_valid, 0);
        wait_cyc(100);
        chk(probes_seen == 0, "R1 no probe before enable", probes_seen, 0);
        chk(vr_code == 8'hC0, "R1 hold at vmax", vr_code, 8'hC0);

        // R4 first margin search
        enable = 1'b1;
        wait_cyc(2000);
        chk(probes_seen > 0, "R4 search probed", probes_seen, 1);
        chk(vr_code == 8'h90, "R4 settle at last pass", vr_code, 8'h90);

        // R5 deadband directed corners
        sample(1008);
        chk(vr_code == 8'h90, "R5 upper band edge", vr_code, 8'h90);
        sample(992);
        chk(vr_code == 8'h90, "R5 lower band edge", vr_code, 8'h90);
        sample(1009);
        chk(vr_code == 8'h8F, "R5 surplus speed", vr_code, 8'h8F);
        sample(991);
        chk(vr_code == 8'h90, "R5 too slow", vr_code, 8'h90);

        // R6 timing error
        @(negedge clk) ted_err = 1'b1;
        @(negedge clk) ted_err = 1'b0;
        wait_cyc(30);
        chk(vr_code == 8'h91, "R6 error step up", vr_code, 8'h91);

        // R7 droop boost
        droop_alarm = 1'b1;
        wait_cyc(30);
        chk(vr_code == 8'h96, "R7 boost applied", vr_code, 8'h96);
        droop_alarm = 1'b0;
        wait_cyc(30);
        chk(vr_code == 8'h91, "R7 boost released", vr_code, 8'h91);

        // R8 cap
        cap_code = 8'h80;
        wait_cyc(30);
        chk(vr_code == 8'h80, "R8 cap clamp", vr_code, 8'h80);
        cap_code = 8'h30;
        wait_cyc(30);
        chk(vr_code == 8'h30, "R8 cap below vmin", vr_code, 8'h30);
        cap_code = 8'hFF;
        wait_cyc(1200);
        chk(vr_code == 8'h91, "R8 cap lifted", vr_code, 8'h91);

        // R5 constrained random tracking
        expc = 8'h91;
        for (int i = 0; i < 24; i++) begin
            cnt = 1000 + int'($urandom_range(40)) - 20;
            sample(cnt);
            expc = track_next(expc, cnt);
            chk(int'(vr_code) == expc, "R5 random track", vr_code, expc);
        end

        // R11 floor of tracking
        vmin_code = vr_code;
        expc = vr_code;
        sample(1030);
        chk(int'(vr_code) == expc, "R11 track floor", vr_code, expc);
        vmin_code = 8'h40;

        // R4 periodic search
        thr = 8'h70;
        search_period = 20'd300;
        wait_cyc(2500);
        search_period = 20'hFFFFF;
        wait_cyc(300);
        chk(vr_code == 8'h70, "R4 periodic search", vr_code, 8'h70);

        // R9 idle
        idle_req = 1'b1;
        wait_cyc(30);
        chk(vr_code == 8'h50, "R9 retention code", vr_code, 8'h50);
        @(negedge clk) ted_err = 1'b1;
        @(negedge clk) ted_err = 1'b0;
        sample(900);
        chk(vr_code == 8'h50, "R9 sensors ignored", vr_code, 8'h50);
        idle_off_sel = 1'b1;
        wait_cyc(30);
        chk(vr_code == 8'h00, "R9 off code", vr_code, 0);

        // R10 wake restarts search
        thr = 8'hA0;
        idle_off_sel = 1'b0;
        idle_req = 1'b0;
        wait_cyc(3500);
        chk(vr_code == 8'hA0, "R10 wake search", vr_code, 8'hA0);

        // R10 performance-state change
        thr = 8'h88;
        @(negedge clk) pstate_change = 1'b1;
        @(negedge clk) pstate_change = 1'b0;
        wait_cyc(2500);
        chk(vr_code == 8'h88, "R10 retarget search", vr_code, 8'h88);

        // R11 search stops at vmin
        vmin_code = 8'h80;
        thr = 8'h10;
        @(negedge clk) pstate_change = 1'b1;
        @(negedge clk) pstate_change = 1'b0;
        wait_cyc(2500);
        chk(vr_code == 8'h80, "R11 search floor", vr_code, 8'h80);

        // R1 disable returns to vmax
        enable = 1'b0;
        wait_cyc(800);
        chk(vr_code == 8'hC0, "R1 disabled at vmax", vr_code, 8'hC0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule